// File: doc/BRIEF.md
# Audio Master Clock Ratio Checker

This block watches the frame (left/right) clock of a serial audio link from inside the master clock domain. It counts the master clock cycles between consecutive rising frame clock edges and decides whether that count is one of the ratios allowed for the selected speed mode. The frame clock has to be derived synchronously from the master clock, so every legal frame period holds an exact whole number of master cycles.

In each speed mode the highest ratio is accepted only while the divide control is set. With divide set, the block produces an enable on every second master cycle and counts only enabled cycles. The internal count is therefore half the true ratio and never goes above the mode's undivided maximum. The reported code always names the true master-to-frame ratio.

Downstream logic uses the ratio code and valid flag to configure its clocking, and the lock flag to decide when the link is steady. The one-cycle error pulse marks every frame period that is illegal or differs from the period before it. A frame clock that stops is detected, and lock is released until edges return.

Top module: `mclk_ratio_checker`

## Requirements
- R1: While reset is held and just after its release: ratio_code = 7, ratio_valid = 0, locked = 0, err_pulse = 0, and mclk_en = 1 when div_en = 0.
- R2: ratio_code encodes the true ratio as 0=128, 1=192, 2=256, 3=384, 4=512, 5=768, 6=1024, 7=none. ratio_valid is 1 exactly when the last measured period was legal, and in that case the code names its ratio. An illegal period gives code 7 with valid 0.
- R3: speed_mode 0 (single) accepts 256, 384, 512 and 768, and accepts 1024 only with div_en = 1.
- R4: speed_mode 1 (double) accepts 128, 192, 256 and 384, and accepts 512 only with div_en = 1.
- R5: speed_mode 2 (quad) accepts 128 and 192, and accepts 256 only with div_en = 1. speed_mode 3 accepts nothing. A ratio outside the mode's set, or a non-standard count, is illegal.
- R6: The top ratio of a mode measured with div_en = 0 is reported as code 7, valid 0, with an error pulse.
- R7: err_pulse is high for exactly one cycle when a period result is illegal, or when its count differs from the previous measured period. Otherwise it stays low.
- R8: locked rises with the result of the third consecutive period that gives the same legal count. It falls with the result of any period that is illegal or differs.
- R9: With div_en = 1, mclk_en alternates 1/0 on successive cycles and only enabled cycles are counted, while the reported ratio is the full master ratio. With div_en = 0, mclk_en stays 1.
- R10: If no rising frame edge is seen for 2048 master cycles, the block clears locked and ratio_valid and sets ratio_code to 7 until edges resume.
- R11: The first rising frame edge after reset or after a stop only opens a measurement. It changes no output and raises no error. The next edge gives the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | Frame (left/right) clock, asynchronous to the sampling flops |
| speed_mode | input | 2 | 0 single, 1 double, 2 quad, 3 reserved |
| div_en | input | 1 | Divide-by-two enable for the master clock |
| mclk_en | output | 1 | Internal master clock enable (alternating when dividing) |
| ratio_code | output | 3 | Measured ratio code, 7 = none |
| ratio_valid | output | 1 | Last measured period was legal |
| locked | output | 1 | Stable legal ratio over consecutive periods |
| err_pulse | output | 1 | One-cycle flag for an illegal or changed period |

## Verification
A frame clock rise driven before a clock edge passes through two synchronizer flops and an edge detector. The period result (ratio_code, ratio_valid, locked, err_pulse) therefore appears at the third rising clock edge after the rise. The driver task pushes one expected result for every rise it makes. A monitor waits three rising clock edges after the frame clock goes high, samples at the next falling edge, and compares, so the one-cycle error pulse is caught in the cycle it exists. The stop state is checked after more than 2048 idle cycles. mclk_en is checked on two successive falling edges, since it changes every cycle.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

   localparam int NUM_RATIOS = 7;
   localparam logic [2:0] CODE_NONE = 3'd7;

   localparam logic [1:0] SPD_SINGLE = 2'd0;
   localparam logic [1:0] SPD_DOUBLE = 2'd1;
   localparam logic [1:0] SPD_QUAD   = 2'd2;

   // ratio for code i: 128 * 2^(i/2), times 1.5 when i is odd
   function automatic int ratio_of(input int idx);
      int base;
      base = 128 << (idx >> 1);
      return (idx % 2 == 1) ? base + base / 2 : base;
   endfunction

   // one bit per code: codes legal in the speed mode (top one included)
   function automatic logic [NUM_RATIOS-1:0] mode_mask(input logic [1:0] mode);
      case (mode)
         SPD_SINGLE: return 7'b111_1100;
         SPD_DOUBLE: return 7'b001_1111;
         SPD_QUAD:   return 7'b000_0111;
         default:    return 7'b000_0000;
      endcase
   endfunction

   // highest code of the mode, which needs the divider
   function automatic logic [2:0] top_code(input logic [1:0] mode);
      case (mode)
         SPD_SINGLE: return 3'd6;
         SPD_DOUBLE: return 3'd4;
         SPD_QUAD:   return 3'd2;
         default:    return CODE_NONE;
      endcase
   endfunction

endpackage

// File: rtl/mcr_frame_sync.sv
module mcr_frame_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_in,
   output logic rise_o
);
   localparam int CHAIN_W = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("mcr_frame_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-2:0], frame_in};
   end

   assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/mcr_period_counter.sv
module mcr_period_counter #(
   parameter int CNT_W      = 12,
   parameter int STOP_LIMIT = 2048
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_en,
   input  logic             edge_i,
   output logic             tick_o,
   output logic [CNT_W-1:0] meas_o,
   output logic             stopped_o
);
   localparam int GAP_W = $clog2(STOP_LIMIT + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [GAP_W-1:0] GAP_END = GAP_W'(STOP_LIMIT);

   generate
      if (CNT_W < 11) begin : g_bad_width
         $error("mcr_period_counter: CNT_W must hold a count of 1024");
      end
      if (STOP_LIMIT <= 1024) begin : g_bad_limit
         $error("mcr_period_counter: STOP_LIMIT must exceed the longest frame");
      end
   endgenerate

   logic             half_q;
   logic [CNT_W-1:0] cnt_q;
   logic [GAP_W-1:0] gap_q;

   assign tick_o = div_en ? half_q : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) half_q <= 1'b1;
      else        half_q <= ~half_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (edge_i) begin
         cnt_q <= CNT_W'(tick_o);
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + CNT_W'(tick_o);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              gap_q <= '0;
      else if (edge_i)         gap_q <= '0;
      else if (gap_q != GAP_END) gap_q <= gap_q + 1'b1;
   end

   assign meas_o    = cnt_q;
   assign stopped_o = (gap_q == GAP_END);

endmodule

// File: rtl/mcr_ratio_classify.sv
module mcr_ratio_classify
   import mcr_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic [CNT_W-1:0] meas_i,
   input  logic             div_en,
   input  logic [1:0]       mode_i,
   output logic [2:0]       code_o,
   output logic             legal_o
);
   localparam int RAT_W = CNT_W + 1;

   logic [RAT_W-1:0]      ratio;
   logic [NUM_RATIOS-1:0] hit;
   logic [NUM_RATIOS-1:0] mask;
   logic [2:0]            top;

   assign ratio = div_en ? {meas_i, 1'b0} : {1'b0, meas_i};
   assign mask  = mode_mask(mode_i);
   assign top   = top_code(mode_i);

   generate
      for (genvar gi = 0; gi < NUM_RATIOS; gi++) begin : g_match
         assign hit[gi] = (32'(ratio) == ratio_of(gi));
      end
   endgenerate

   always_comb begin
      code_o = CODE_NONE;
      for (int i = 0; i < NUM_RATIOS; i++) begin
         if (hit[i]) code_o = 3'(i);
      end
      legal_o = (|(hit & mask)) && !((code_o == top) && !div_en);
   end

endmodule

// File: rtl/mclk_ratio_checker.sv
module mclk_ratio_checker
   import mcr_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int CNT_W        = 12,
   parameter int STOP_LIMIT   = 2048,
   parameter int LOCK_PERIODS = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_clk,
   input  logic [1:0] speed_mode,
   input  logic       div_en,
   output logic       mclk_en,
   output logic [2:0] ratio_code,
   output logic       ratio_valid,
   output logic       locked,
   output logic       err_pulse
);
   localparam int STREAK_W = $clog2(LOCK_PERIODS + 1);
   localparam logic [STREAK_W-1:0] STREAK_FULL = STREAK_W'(LOCK_PERIODS);

   generate
      if (LOCK_PERIODS < 1) begin : g_bad_lock
         $error("mclk_ratio_checker: LOCK_PERIODS must be at least 1");
      end
   endgenerate

   logic             rise;
   logic             stopped;
   logic [CNT_W-1:0] meas;
   logic [2:0]       cls_code;
   logic             cls_legal;

   mcr_frame_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_in (frame_clk),
      .rise_o   (rise)
   );

   mcr_period_counter #(.CNT_W(CNT_W), .STOP_LIMIT(STOP_LIMIT)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_en    (div_en),
      .edge_i    (rise),
      .tick_o    (mclk_en),
      .meas_o    (meas),
      .stopped_o (stopped)
   );

   mcr_ratio_classify #(.CNT_W(CNT_W)) u_cls (
      .meas_i  (meas),
      .div_en  (div_en),
      .mode_i  (speed_mode),
      .code_o  (cls_code),
      .legal_o (cls_legal)
   );

   logic                have_edge_q;
   logic                have_meas_q;
   logic [CNT_W-1:0]    prev_q;
   logic [STREAK_W-1:0] streak_q;
   logic [STREAK_W-1:0] streak_nxt;
   logic                same;
   logic [2:0]          code_q;
   logic                valid_q;
   logic                lock_q;
   logic                err_q;

   assign same = have_meas_q && (meas == prev_q);

   always_comb begin
      if (!cls_legal)                streak_nxt = '0;
      else if (!same)                streak_nxt = STREAK_W'(1);
      else if (streak_q == STREAK_FULL) streak_nxt = streak_q;
      else                           streak_nxt = streak_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_edge_q <= 1'b0;
         have_meas_q <= 1'b0;
         prev_q      <= '0;
         streak_q    <= '0;
         code_q      <= CODE_NONE;
         valid_q     <= 1'b0;
         lock_q      <= 1'b0;
         err_q       <= 1'b0;
      end else if (rise) begin
         have_edge_q <= 1'b1;
         err_q       <= 1'b0;
         if (have_edge_q) begin
            have_meas_q <= 1'b1;
            prev_q      <= meas;
            streak_q    <= streak_nxt;
            code_q      <= cls_legal ? cls_code : CODE_NONE;
            valid_q     <= cls_legal;
            lock_q      <= (streak_nxt == STREAK_FULL);
            err_q       <= !cls_legal || (have_meas_q && !same);
         end
      end else if (stopped) begin
         have_edge_q <= 1'b0;
         have_meas_q <= 1'b0;
         streak_q    <= '0;
         code_q      <= CODE_NONE;
         valid_q     <= 1'b0;
         lock_q      <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         err_q <= 1'b0;
      end
   end

   assign ratio_code  = code_q;
   assign ratio_valid = valid_q;
   assign locked      = lock_q;
   assign err_pulse   = err_q;

endmodule

// File: rtl/mcr_checker.sv
module mcr_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       div_en,
   input logic       mclk_en,
   input logic [2:0] ratio_code,
   input logic       ratio_valid,
   input logic       locked,
   input logic       err_pulse
);
   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> !err_pulse); // R7
   AST_VALID_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_valid |-> (ratio_code != 3'd7)); // R2
   AST_INVALID_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !ratio_valid |-> (ratio_code == 3'd7)); // R2
   AST_LOCK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> ratio_valid); // R8
   AST_ERR_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> !locked); // R8
   AST_LOCK_RISE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(ratio_valid)); // R8
   AST_DIV_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      (div_en && mclk_en) |=> (!div_en || !mclk_en)); // R9
   AST_TOP_NEEDS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_valid && ratio_code == 3'd6) |-> div_en); // R6
endmodule

bind mclk_ratio_checker mcr_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .div_en      (div_en),
   .mclk_en     (mclk_en),
   .ratio_code  (ratio_code),
   .ratio_valid (ratio_valid),
   .locked      (locked),
   .err_pulse   (err_pulse)
);

// File: tb/mclk_ratio_checker_test.sv
module mclk_ratio_checker_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_clk = 1'b0;
   logic [1:0] speed_mode = 2'd0;
   logic       div_en = 1'b0;
   logic       mclk_en;
   logic [2:0] ratio_code;
   logic       ratio_valid;
   logic       locked;
   logic       err_pulse;

   always #5 clk = ~clk;

   mclk_ratio_checker uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_clk   (frame_clk),
      .speed_mode  (speed_mode),
      .div_en      (div_en),
      .mclk_en     (mclk_en),
      .ratio_code  (ratio_code),
      .ratio_valid (ratio_valid),
      .locked      (locked),
      .err_pulse   (err_pulse)
   );

   typedef struct {
      int    code;
      int    valid;
      int    lock;
      int    err;
      string tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 0;

   // reference model state
   bit   m_have_edge, m_have_meas;
   int   m_prev, m_streak, m_last_len;
   exp_t m_out;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int code_of(int n);
      case (n)
         128: return 0;   192: return 1;   256: return 2;  384: return 3;
         512: return 4;   768: return 5;   1024: return 6;
         default: return 7;
      endcase
   endfunction

   function automatic bit legal_of(int mode, bit div, int n);
      int c;
      c = code_of(n);
      case (mode)
         0: return (c >= 2 && c <= 5) || (c == 6 && div);
         1: return (c <= 3) || (c == 4 && div);
         2: return (c <= 1) || (c == 2 && div);
         default: return 0;
      endcase
   endfunction

   function automatic void model_clear();
      m_have_edge = 0; m_have_meas = 0; m_streak = 0; m_prev = 0;
      m_out.code = 7; m_out.valid = 0; m_out.lock = 0; m_out.err = 0;
   endfunction

   function automatic void model_edge(int n);
      bit lg;
      lg = legal_of(speed_mode, div_en, n);
      m_out.err = (!lg || (m_have_meas && n != m_prev)) ? 1 : 0;
      if (!lg) m_streak = 0;
      else if (m_have_meas && n == m_prev) m_streak = (m_streak < 3) ? m_streak + 1 : 3;
      else m_streak = 1;
      m_out.code  = lg ? code_of(n) : 7;
      m_out.valid = lg;
      m_out.lock  = (m_streak == 3);
      m_prev = n;
      m_have_meas = 1;
   endfunction

   // driver: one frame period per call, result of the previous period pushed
   task automatic frames(int n, int cnt, string tag);
      for (int k = 0; k < cnt; k++) begin
         if (!m_have_edge) begin
            m_have_edge = 1;
            m_out.err = 0;
            m_out.tag = "R11";
         end else begin
            model_edge(m_last_len);
            m_out.tag = tag;
         end
         q.push_back(m_out);
         frame_clk = 1'b1;
         repeat (n / 2) @(negedge clk);
         frame_clk = 1'b0;
         repeat (n - n / 2) @(negedge clk);
         m_last_len = n;
      end
   endtask

   // monitor: result due at third rising clock edge after the frame rise
   initial begin
      forever begin
         @(posedge frame_clk);
         repeat (3) @(posedge clk);
         @(negedge clk);
         if (q.size() == 0) begin
            chk("R7", "unexpected result", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "ratio_code", int'(ratio_code), e.code);
            chk(e.tag, "ratio_valid", int'(ratio_valid), e.valid);
            chk("R8",  "locked", int'(locked), e.lock);
            chk("R7",  "err_pulse", int'(err_pulse), e.err);
         end
      end
   end

   // idle until stopped, check the cleared state, then apply new settings
   task automatic restart(int mode, bit div);
      frame_clk = 1'b0;
      repeat (2100) @(negedge clk);
      chk("R10", "stopped code", int'(ratio_code), 7);
      chk("R10", "stopped valid", int'(ratio_valid), 0);
      chk("R10", "stopped lock", int'(locked), 0);
      speed_mode = mode[1:0];
      div_en = div;
      repeat (2) @(negedge clk);
      begin
         int a, b;
         a = mclk_en;
         @(negedge clk);
         b = mclk_en;
         if (div) chk("R9", "mclk_en alternates", int'(a != b), 1);
         else     chk("R9", "mclk_en held high", a + b, 2);
      end
      model_clear();
   endtask

   initial begin
      model_clear();
      m_last_len = 0;
      repeat (4) @(negedge clk);
      chk("R1", "reset code", int'(ratio_code), 7);
      chk("R1", "reset valid", int'(ratio_valid), 0);
      chk("R1", "reset lock", int'(locked), 0);
      chk("R1", "reset err", int'(err_pulse), 0);
      chk("R1", "reset mclk_en", int'(mclk_en), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "post-reset code", int'(ratio_code), 7);

      restart(0, 0);
      frames(256, 5, "R3");
      frames(384, 3, "R3");
      frames(512, 2, "R3");
      frames(768, 2, "R3");
      frames(1024, 3, "R6");
      frames(300, 2, "R5");
      frames(256, 1, "R3");

      restart(0, 1);
      frames(1024, 4, "R9");
      frames(256, 3, "R9");

      restart(1, 0);
      frames(128, 4, "R4");
      frames(192, 2, "R4");
      frames(512, 2, "R6");
      frames(1024, 2, "R4");
      frames(128, 1, "R4");

      restart(1, 1);
      frames(512, 4, "R4");

      restart(2, 0);
      frames(128, 2, "R5");
      frames(192, 2, "R5");
      frames(256, 2, "R6");
      frames(384, 2, "R5");
      frames(128, 1, "R5");

      restart(2, 1);
      frames(256, 4, "R5");

      restart(3, 0);
      frames(256, 3, "R5");

      restart(0, 0);
      chk("R7", "queue drained", q.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule